// File: doc/BRIEF.md
# Rolling Shutter Frame Sequencer

This block paces frame capture for a rolling-shutter image sensor. It requests line readouts one at a time through a request/done handshake with the sensor (each completed readout also resets that line for its next integration), walks a line pointer through the frame, and decides, frame by frame, whether the lines being read are delivered (frame valid high) or discarded as dummy frames. Between readouts it can pause and drive a shutter/strobe output so that every line sees the same exposure.

Four synchronization modes are offered. Periodic mode reads frames continuously, optionally inserting a programmed shutter pause between frames. Two triggered modes wait for an external edge: one reads a hidden flush frame before the shutter pause, the other goes straight to the shutter pause. The pulse-width mode holds the shutter open for as long as an external sync level stays active. In every triggered mode the sequencer keeps reading dummy frames while it waits, so dark current never builds up in the pixel array.

States: `ST_DUMMY_WAIT` (dummy readout, waiting), `ST_DUMMY_PRE` (flush frame after a trigger), `ST_EXPOSE` (timed shutter pause), `ST_PULSE` (shutter follows the sync level), `ST_READ` (valid readout). Transitions: reset enters `ST_DUMMY_WAIT`; from it an accepted edge leads to `ST_DUMMY_PRE` (mode 001), to `ST_EXPOSE` or `ST_READ` (mode 010, by shutter time zero or not) or to `ST_PULSE` (mode 011), and in mode 000 a frame end leads to `ST_EXPOSE` or `ST_READ`; `ST_DUMMY_PRE` ends its frame into `ST_EXPOSE` or `ST_READ`; `ST_EXPOSE` ends its count into `ST_READ`; `ST_PULSE` ends on the falling sync level into `ST_READ`; `ST_READ` ends its frame into `ST_DUMMY_WAIT`, or in mode 000 into `ST_EXPOSE` or back into `ST_READ`.

Top module: `frame_seq`

## Requirements
- R1: While reset is held, the sequencer is in dummy readout: `line_req`=1, `line_addr`=0, `frame_valid`=0, `line_valid`=0, `shutter_out` equals `shut_inv`, and `wait_trig`=1 when `mode_sel` is 001.
- R2: Each `line_done` seen while `line_req` is high advances `line_addr` by one, wrapping from LINES-1 to 0; any state change returns it to 0, and it never exceeds LINES-1.
- R3: With `mode_sel`=000 and `shutter_time`=0, after the first dummy frame every frame is valid, read back to back with `frame_valid` held high and the shutter never active.
- R4: With `mode_sel`=000 and `shutter_time`=N>0, each gap between valid frames holds `line_req` low and the shutter active for exactly N*TICK_DIV clock cycles; each valid frame delivers LINES `line_valid` strobes.
- R5: With `mode_sel`=001, an accepted trigger aborts the dummy frame, restarts at line 0, reads one flush frame of LINES lines with `frame_valid` low, then the shutter pause, then one valid frame of LINES lines with `frame_valid` high, then returns to waiting.
- R6: With `mode_sel`=010, an accepted trigger skips the flush frame: shutter pause of N*TICK_DIV cycles, then one valid frame of LINES lines.
- R7: With `mode_sel`=011, the shutter is active for exactly as many cycles as the conditioned sync level stays active, after which one valid frame of LINES lines is read.
- R8: `wait_trig` is high only while dummy frames are read awaiting a trigger in modes 001, 010 or 011; it is low in mode 000 and never coincides with `frame_valid`.
- R9: `trig_src_sel`=0 listens to `trig_a`, 1 to `trig_b`; the unselected input has no effect. `trig_fall_edge`=1 makes a falling edge (and, in mode 011, a low level) the active one.
- R10: `shut_inv`=1 inverts `shutter_out`: idle level 1, active level 0.
- R11: A trigger or sync pulse shorter than MIN_PULSE clock cycles is ignored.
- R12: Triggers arriving during the flush, shutter or valid-readout phase are ignored and not stored: exactly one valid frame follows the accepted trigger.
- R13: With a reserved mode code (100 to 111), no trigger is accepted, no valid frame is read, the shutter stays inactive and `wait_trig` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Synchronization mode: 000 periodic, 001 triggered with flush, 010 triggered without flush, 011 pulse-width, others reserved |
| trig_src_sel | input | 1 | Trigger source: 0 `trig_a`, 1 `trig_b` |
| trig_fall_edge | input | 1 | 1 makes the falling edge / low level active |
| shut_inv | input | 1 | Shutter output polarity inversion |
| shutter_time | input | 16 | Shutter pause length in steps of TICK_DIV cycles |
| trig_a | input | 1 | Trigger/sync input A (asynchronous) |
| trig_b | input | 1 | Trigger/sync input B (asynchronous) |
| line_done | input | 1 | Sensor strobe: the requested line readout finished |
| line_req | output | 1 | Request to read out and reset line `line_addr` |
| line_addr | output | $clog2(LINES) | Line pointer |
| line_valid | output | 1 | One-cycle strobe per completed line of a valid frame |
| frame_valid | output | 1 | High throughout a valid frame readout |
| shutter_out | output | 1 | Shutter/strobe output, polarity set by `shut_inv` |
| wait_trig | output | 1 | Idle in dummy readout awaiting a trigger |

## Verification
The bench builds the block with LINES=4, TICK_DIV=2 and MIN_PULSE=3, so a whole frame is a dozen cycles with the bench's sensor model and a shutter step is two cycles. That puts line-pointer wrap, several back-to-back frames, exact shutter widths, the flush frame and glitches one cycle below the acceptance width all within a few dozen cycles per scenario, and lets every mode and polarity be run from reset in turn.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [2:0] {
        ST_DUMMY_WAIT,
        ST_DUMMY_PRE,
        ST_EXPOSE,
        ST_PULSE,
        ST_READ
    } seq_state_t;

    localparam logic [2:0] MODE_FREE     = 3'b000;
    localparam logic [2:0] MODE_TRIG     = 3'b001;
    localparam logic [2:0] MODE_TRIG_NR  = 3'b010;
    localparam logic [2:0] MODE_PULSE    = 3'b011;

endpackage

// File: rtl/fsq_trig_filter.sv
// Source select, polarity, two-flop synchronizer and minimum-width filter.
module fsq_trig_filter #(
    parameter int MIN_PULSE = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_a,
    input  logic src_b,
    input  logic src_sel,
    input  logic invert,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_PULSE - 1);

    logic       raw_in;
    logic [1:0] sync_q;
    logic [CW-1:0] cnt_q;
    logic       flip;

    assign raw_in = (src_sel ? src_b : src_a) ^ invert;
    assign flip   = (sync_q[1] != level) && (cnt_q == CNT_LAST);
    assign rise   = flip && sync_q[1];
    assign fall   = flip && !sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            cnt_q  <= '0;
            level  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (flip) begin
                level <= sync_q[1];
                cnt_q <= '0;
            end else if (sync_q[1] != level) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/fsq_step_timer.sv
// Counts a number of steps, each TICK_DIV clock cycles long.
module fsq_step_timer #(
    parameter int TICK_DIV = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] steps,
    output logic        done
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic          busy_q;
    logic [PW-1:0] pre_q;
    logic [15:0]   rem_q;

    assign done = busy_q && (pre_q == '0) && (rem_q == 16'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pre_q  <= '0;
            rem_q  <= '0;
        end else if (start) begin
            busy_q <= (steps != 16'd0);
            pre_q  <= PRE_LAST;
            rem_q  <= steps;
        end else if (busy_q) begin
            if (pre_q == '0) begin
                pre_q <= PRE_LAST;
                if (rem_q == 16'd1) begin
                    busy_q <= 1'b0;
                end
                rem_q <= rem_q - 16'd1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import fsq_pkg::*;
#(
    parameter int LINES     = 1184,
    parameter int TICK_DIV  = 500,
    parameter int MIN_PULSE = 50,
    localparam int LW       = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic          trig_src_sel,
    input  logic          trig_fall_edge,
    input  logic          shut_inv,
    input  logic [15:0]   shutter_time,
    input  logic          trig_a,
    input  logic          trig_b,
    input  logic          line_done,
    output logic          line_req,
    output logic [LW-1:0] line_addr,
    output logic          line_valid,
    output logic          frame_valid,
    output logic          shutter_out,
    output logic          wait_trig
);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    seq_state_t st_q, st_d;
    logic [LW-1:0] addr_q;
    logic trg_lvl, trg_rise, trg_fall;
    logic exp_start, exp_done;
    logic frame_end, shut_nz, shut_act;
    logic is_free, is_trig, is_trig_nr, is_pulse;

    assign is_free    = (mode_sel == MODE_FREE);
    assign is_trig    = (mode_sel == MODE_TRIG);
    assign is_trig_nr = (mode_sel == MODE_TRIG_NR);
    assign is_pulse   = (mode_sel == MODE_PULSE);
    assign shut_nz    = (shutter_time != 16'd0);
    assign frame_end  = line_done && (addr_q == LAST_LINE);
    assign exp_start  = (st_d == ST_EXPOSE) && (st_q != ST_EXPOSE);

    fsq_trig_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_a   (trig_a),
        .src_b   (trig_b),
        .src_sel (trig_src_sel),
        .invert  (trig_fall_edge),
        .level   (trg_lvl),
        .rise    (trg_rise),
        .fall    (trg_fall)
    );

    fsq_step_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (exp_start),
        .steps (shutter_time),
        .done  (exp_done)
    );

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DUMMY_WAIT: begin
                if (trg_rise && is_trig)
                    st_d = ST_DUMMY_PRE;
                else if (trg_rise && is_trig_nr)
                    st_d = shut_nz ? ST_EXPOSE : ST_READ;
                else if (trg_rise && is_pulse)
                    st_d = ST_PULSE;
                else if (frame_end && is_free)
                    st_d = shut_nz ? ST_EXPOSE : ST_READ;
            end
            ST_DUMMY_PRE: if (frame_end) st_d = shut_nz ? ST_EXPOSE : ST_READ;
            ST_EXPOSE:    if (exp_done)  st_d = ST_READ;
            ST_PULSE:     if (trg_fall)  st_d = ST_READ;
            ST_READ: begin
                if (frame_end)
                    st_d = is_free ? (shut_nz ? ST_EXPOSE : ST_READ) : ST_DUMMY_WAIT;
            end
            default:      st_d = ST_DUMMY_WAIT;
        endcase
    end

    // State register and line pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_DUMMY_WAIT;
            addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                addr_q <= '0;
            else if (line_req && line_done)
                addr_q <= (addr_q == LAST_LINE) ? '0 : addr_q + 1'b1;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        line_req    = 1'b0;
        frame_valid = 1'b0;
        shut_act    = 1'b0;
        wait_trig   = 1'b0;
        unique case (st_q)
            ST_DUMMY_WAIT: begin
                line_req  = 1'b1;
                wait_trig = is_trig || is_trig_nr || is_pulse;
            end
            ST_DUMMY_PRE:  line_req = 1'b1;
            ST_EXPOSE:     shut_act = 1'b1;
            ST_PULSE:      shut_act = 1'b1;
            ST_READ: begin
                line_req    = 1'b1;
                frame_valid = 1'b1;
            end
            default: ;
        endcase
        line_valid  = frame_valid && line_done;
        shutter_out = shut_act ^ shut_inv;
    end

    assign line_addr = addr_q;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int LINES = 1184,
    parameter int LW    = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode_sel,
    input logic          shut_inv,
    input logic          line_req,
    input logic [LW-1:0] line_addr,
    input logic          line_valid,
    input logic          frame_valid,
    input logic          shutter_out,
    input logic          wait_trig
);
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_addr <= LW'(LINES - 1)) else $error("line pointer out of range"); // R2

    AST_PAUSE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !line_req |-> line_addr == '0) else $error("pointer moved in pause"); // R4

    AST_SHUT_PAUSES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (shutter_out != shut_inv) |-> !line_req) else $error("readout during shutter"); // R4

    AST_FV_SHUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> shutter_out == shut_inv) else $error("shutter active in valid frame"); // R4

    AST_LV_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid && line_req) else $error("line strobe outside frame"); // R5

    AST_FV_STARTS_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> line_addr == '0) else $error("valid frame not at line 0"); // R5

    AST_WAIT_NO_FV: assert property (@(posedge clk) disable iff (!rst_n)
        wait_trig |-> !frame_valid && line_req) else $error("waiting while valid"); // R8

    AST_WAIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        wait_trig |-> (mode_sel == 3'b001 || mode_sel == 3'b010 || mode_sel == 3'b011))
        else $error("waiting in non-triggered mode"); // R8
endmodule

bind frame_seq frame_seq_chk #(.LINES(LINES), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .shut_inv    (shut_inv),
    .line_req    (line_req),
    .line_addr   (line_addr),
    .line_valid  (line_valid),
    .frame_valid (frame_valid),
    .shutter_out (shutter_out),
    .wait_trig   (wait_trig)
);

// File: tb/sim_frame_seq.sv
`timescale 1ns/1ps
module sim_frame_seq;
    localparam int LINES = 4;
    localparam int TDIV  = 2;
    localparam int MINP  = 3;
    localparam int LW    = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic trig_src_sel = 1'b0, trig_fall_edge = 1'b0, shut_inv = 1'b0;
    logic [15:0] shutter_time = 16'd0;
    logic trig_a = 1'b0, trig_b = 1'b0, line_done = 1'b0;
    logic line_req, line_valid, frame_valid, shutter_out, wait_trig;
    logic [LW-1:0] line_addr;

    int errors = 0, checks = 0;
    int n_fvr = 0, n_vl = 0, n_pre = 0, n_sh = 0, n_fv = 0, n_wait = 0;
    int n_bad_sh = 0, n_chg = 0, n_abad = 0, run = 0, last_run = 0;
    int addr_at_fall = -1;
    logic fv_q = 1'b0, wt_q = 1'b0;
    logic [LW-1:0] a_q = '0;
    int b_fvr, b_vl, b_pre, b_sh, b_fv, b_wait, b_chg, b_abad;

    always #10 clk = ~clk;

    frame_seq #(.LINES(LINES), .TICK_DIV(TDIV), .MIN_PULSE(MINP)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_src_sel(trig_src_sel),
        .trig_fall_edge(trig_fall_edge), .shut_inv(shut_inv), .shutter_time(shutter_time),
        .trig_a(trig_a), .trig_b(trig_b), .line_done(line_done), .line_req(line_req),
        .line_addr(line_addr), .line_valid(line_valid), .frame_valid(frame_valid),
        .shutter_out(shutter_out), .wait_trig(wait_trig));

    // Sensor model: a line takes three cycles of request
    initial begin
        int ctr = 0;
        forever begin
            @(posedge clk); #2;
            if (line_req) begin
                if (ctr == 2) begin line_done = 1'b1; ctr = 0; end
                else begin line_done = 1'b0; ctr++; end
            end else begin
                line_done = 1'b0; ctr = 0;
            end
        end
    end

    // Output observer
    always @(negedge clk) begin
        logic act;
        act = shutter_out ^ shut_inv;
        if (frame_valid && !fv_q) n_fvr++;
        if (frame_valid) n_fv++;
        if (line_valid) n_vl++;
        if (line_req && !frame_valid && !wait_trig && line_done) n_pre++;
        if (act) begin
            n_sh++; run++;
            if (line_req) n_bad_sh++;
        end else begin
            if (run != 0) last_run = run;
            run = 0;
        end
        if (wait_trig) n_wait++;
        if (!wait_trig && wt_q) addr_at_fall = int'(line_addr);
        if (line_addr != a_q) begin
            n_chg++;
            if (int'(line_addr) != (int'(a_q) + 1) % LINES) n_abad++;
        end
        fv_q = frame_valid; wt_q = wait_trig; a_q = line_addr;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic snap();
        b_fvr = n_fvr; b_vl = n_vl; b_pre = n_pre; b_sh = n_sh; b_fv = n_fv;
        b_wait = n_wait; b_chg = n_chg; b_abad = n_abad;
    endtask

    task automatic do_reset(input logic [2:0] m, input int sh, input bit src,
                            input bit fe, input bit inv);
        @(posedge clk); #1;
        rst_n = 1'b0;
        mode_sel = m; shutter_time = 16'(sh); trig_src_sel = src;
        trig_fall_edge = fe; shut_inv = inv;
        trig_a = 1'b0; trig_b = fe;
        cyc(3);
        rst_n = 1'b1;
        cyc(20);
    endtask

    // Toggle the chosen input away from idle for w cycles
    task automatic pulse(input bit on_b, input int w);
        @(posedge clk); #1;
        if (on_b) trig_b = ~trig_b; else trig_a = ~trig_a;
        cyc(w);
        if (on_b) trig_b = ~trig_b; else trig_a = ~trig_a;
    endtask

    task automatic t_reset_state();
        @(posedge clk); #1;
        rst_n = 1'b0; mode_sel = 3'b001; shut_inv = 1'b0;
        cyc(2);
        chk(line_req == 1'b1,    "R1 line_req", line_req, 1);
        chk(line_addr == '0,     "R1 line_addr", int'(line_addr), 0);
        chk(frame_valid == 1'b0 && line_valid == 1'b0, "R1 valids", frame_valid, 0);
        chk(shutter_out == 1'b0, "R1 shutter", shutter_out, 0);
        chk(wait_trig == 1'b1,   "R1 wait_trig", wait_trig, 1);
    endtask

    task automatic t_line_step();
        do_reset(3'b001, 0, 0, 0, 0);
        snap();
        cyc(60);
        chk(n_abad - b_abad == 0, "R2 pointer step order", n_abad - b_abad, 0);
        chk(n_chg - b_chg == 20,  "R2 pointer changes", n_chg - b_chg, 20);
        chk(n_wait - b_wait == 60, "R8 waiting in mode 001", n_wait - b_wait, 60);
    endtask

    task automatic t_free_zero();
        do_reset(3'b000, 0, 0, 0, 0);
        cyc(20);
        snap();
        cyc(72);
        chk(n_fv - b_fv == 72, "R3 frame_valid continuous", n_fv - b_fv, 72);
        chk(n_vl - b_vl == 24, "R3 lines delivered", n_vl - b_vl, 24);
        chk(n_sh - b_sh == 0,  "R3 shutter idle", n_sh - b_sh, 0);
        chk(n_wait - b_wait == 0, "R8 no wait in mode 000", n_wait - b_wait, 0);
    endtask

    task automatic t_free_shut();
        int guard = 0;
        do_reset(3'b000, 5, 0, 0, 0);
        while (!(shutter_out ^ shut_inv) && guard < 200) begin cyc(1); guard++; end
        while ((shutter_out ^ shut_inv) && guard < 200) begin cyc(1); guard++; end
        cyc(1);
        chk(last_run == 5 * TDIV, "R4 shutter width", last_run, 5 * TDIV);
        chk(n_bad_sh == 0, "R4 readout paused", n_bad_sh, 0);
        snap();
        while (!(shutter_out ^ shut_inv) && guard < 400) begin cyc(1); guard++; end
        chk(n_vl - b_vl == LINES, "R4 lines per frame", n_vl - b_vl, LINES);
    endtask

    task automatic t_trig_full();
        do_reset(3'b001, 3, 0, 0, 0);
        snap();
        pulse(0, 5);
        cyc(100);
        chk(addr_at_fall == 0, "R5 restart at line 0", addr_at_fall, 0);
        chk(n_pre - b_pre == LINES, "R5 flush frame lines", n_pre - b_pre, LINES);
        chk(last_run == 3 * TDIV, "R5 shutter width", last_run, 3 * TDIV);
        chk(n_vl - b_vl == LINES, "R5 valid lines", n_vl - b_vl, LINES);
        chk(n_fvr - b_fvr == 1, "R5 one valid frame", n_fvr - b_fvr, 1);
        chk(wait_trig == 1'b1, "R8 back to waiting", wait_trig, 1);
    endtask

    task automatic t_trig_nr();
        do_reset(3'b010, 3, 0, 0, 0);
        snap();
        pulse(0, 5);
        cyc(80);
        chk(n_pre - b_pre == 0, "R6 no flush frame", n_pre - b_pre, 0);
        chk(last_run == 3 * TDIV, "R6 shutter width", last_run, 3 * TDIV);
        chk(n_vl - b_vl == LINES, "R6 valid lines", n_vl - b_vl, LINES);
    endtask

    task automatic t_pulse_mode();
        do_reset(3'b011, 0, 0, 0, 0);
        snap();
        pulse(0, 9);
        cyc(60);
        chk(last_run == 9, "R7 shutter follows sync width", last_run, 9);
        chk(n_vl - b_vl == LINES, "R7 valid lines", n_vl - b_vl, LINES);
        chk(n_pre - b_pre == 0, "R7 no flush frame", n_pre - b_pre, 0);
    endtask

    task automatic t_src_pol();
        do_reset(3'b010, 2, 1, 0, 0);
        snap();
        pulse(0, 6);
        cyc(60);
        chk(n_vl - b_vl == 0, "R9 unselected input ignored", n_vl - b_vl, 0);
        pulse(1, 6);
        cyc(60);
        chk(n_vl - b_vl == LINES, "R9 selected input", n_vl - b_vl, LINES);
        do_reset(3'b010, 2, 1, 1, 0);
        snap();
        cyc(40);
        chk(n_vl - b_vl == 0, "R9 idle-high no trigger", n_vl - b_vl, 0);
        pulse(1, 6);
        cyc(60);
        chk(n_vl - b_vl == LINES, "R9 falling edge triggers", n_vl - b_vl, LINES);
    endtask

    task automatic t_shut_inv();
        do_reset(3'b010, 3, 0, 0, 1);
        chk(shutter_out == 1'b1, "R10 idle level inverted", shutter_out, 1);
        snap();
        pulse(0, 5);
        cyc(60);
        chk(n_sh - b_sh == 3 * TDIV, "R10 active low width", n_sh - b_sh, 3 * TDIV);
    endtask

    task automatic t_glitch();
        do_reset(3'b010, 2, 0, 0, 0);
        snap();
        pulse(0, MINP - 1);
        cyc(60);
        chk(n_vl - b_vl == 0 && n_sh - b_sh == 0, "R11 short pulse ignored", n_vl - b_vl, 0);
        chk(n_wait - b_wait == 60 + MINP - 1 + 1, "R11 still waiting",
            n_wait - b_wait, 60 + MINP);
    endtask

    task automatic t_ignore();
        int guard = 0;
        do_reset(3'b010, 10, 0, 0, 0);
        snap();
        pulse(0, 5);
        while (!(shutter_out ^ shut_inv) && guard < 100) begin cyc(1); guard++; end
        pulse(0, 5);
        while (!frame_valid && guard < 200) begin cyc(1); guard++; end
        pulse(0, 5);
        cyc(60);
        chk(n_fvr - b_fvr == 1, "R12 single valid frame", n_fvr - b_fvr, 1);
        chk(n_vl - b_vl == LINES, "R12 valid lines", n_vl - b_vl, LINES);
        chk(n_sh - b_sh == 10 * TDIV, "R12 single shutter", n_sh - b_sh, 10 * TDIV);
    endtask

    task automatic t_reserved();
        do_reset(3'b101, 2, 0, 0, 0);
        snap();
        pulse(0, 6);
        cyc(80);
        chk(n_fv - b_fv == 0, "R13 no valid frame", n_fv - b_fv, 0);
        chk(n_sh - b_sh == 0, "R13 shutter idle", n_sh - b_sh, 0);
        chk(n_wait - b_wait == 0, "R13 not waiting", n_wait - b_wait, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset_state();
        t_line_step();
        t_free_zero();
        t_free_shut();
        t_trig_full();
        t_trig_nr();
        t_pulse_mode();
        t_src_pol();
        t_shut_inv();
        t_glitch();
        t_ignore();
        t_reserved();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule